// File: doc/BRIEF.md
# Serial Load/Store Byte Lane Unit

This unit sits between a one-bit-wide datapath and a 32-bit parallel data bus. Its storage is a single 32-bit register built from four byte stages chained in series. The register is put to three uses, chosen by a mode input. In store mode, serial source-register bits are shifted in at the top, and the register contents drive the bus write word. In load mode, a bus word is captured in parallel and then shifted out one bit per step from a tap chosen by the address offset. In shift mode, the low bits of the same register count down the steps of a shift instruction.

The bus byte selects and a misalignment flag are decoded from the two address LSBs and the access size. In load mode, an externally supplied bit counter marks where the valid bits of a byte or halfword run out. From that point the serial output is filled with zeros or with the sign bit.

Top module: `serial_lane_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released with no further activity, `wdat` is 0 and `sh_done_r` is 0.
- R2: `size` encodes 00 = byte, 01 = halfword, 10 = word. Lane k is `wdat[8k+7:8k]`, and its select is `byte_sel[k]`. `byte_sel[0]` = (offset==0). `byte_sel[1]` = offset==1, or word, or (halfword and offset bit 1 low). `byte_sel[2]` = offset==2, or word. `byte_sel[3]` = offset==3, or word, or (halfword and offset bit 1 high).
- R3: `misalign` is high for a halfword with `addr_lsb[0]`=1, or for a word with `addr_lsb`!=0. Otherwise it is low.
- R4: `mode` encodes 00 = store, 01 = load, 10 = shift. In store mode, each clock with `en` high shifts the register right by one bit and puts `rs2_bit` into bit 31. `wdat` always shows the register.
- R5: In load mode, `ld_capture` high loads `bus_rdat` into the register on that clock. This takes priority over a simultaneous `en`.
- R6: In load mode, `rd_bit` shows register bit 8×`addr_lsb` while the access is still valid. Each enabled load clock without capture shifts the register right by one bit and puts 0 into bit 31. In any mode, a clock with `en`, `ld_capture` and `sh_load` all low leaves the register unchanged.
- R7: A load is valid while `bit_cnt` < 8 (byte) or < 16 (halfword), and always for a word. After that, `rd_bit` is 0 when `signed_ld` is low. When `signed_ld` is high, `rd_bit` repeats the last valid bit that was shifted out.
- R8: In shift mode, `sh_load` writes `sh_amt` into register bits 5:0 and leaves bits 31:6 untouched. This takes priority over `en`. Each clock with `en` high and a nonzero count decrements the count, and a zero count stays zero. `sh_done` is high exactly when the mode is shift and bits 5:0 are zero.
- R9: `sh_done_r` equals `sh_done` from the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 store, 01 load, 10 shift |
| size | input | 2 | 00 byte, 01 halfword, 10 word |
| addr_lsb | input | 2 | Two low address bits |
| en | input | 1 | Data enable: one serial step |
| rs2_bit | input | 1 | Serial store data in |
| ld_capture | input | 1 | Capture bus word (load mode) |
| bus_rdat | input | 32 | Bus read word |
| signed_ld | input | 1 | Sign-extend the load |
| bit_cnt | input | 5 | Index of the current serial bit |
| sh_load | input | 1 | Load the shift count (shift mode) |
| sh_amt | input | 6 | Shift amount |
| wdat | output | 32 | Register contents / bus write word |
| byte_sel | output | 4 | Bus byte selects |
| misalign | output | 1 | Misaligned access flag |
| rd_bit | output | 1 | Serial load data out |
| sh_done | output | 1 | Shift count exhausted |
| sh_done_r | output | 1 | Registered copy of sh_done |

## Verification
Two register writes can be requested in the same cycle. A parallel capture can meet an enabled load step, and a count load can meet an enabled shift step. The bench provokes both by raising `en` together with `ld_capture` or `sh_load`. It judges the outcome on the next cycle: `wdat` must equal the captured bus word unshifted, and `wdat[5:0]` must equal the loaded amount undecremented with bits 31:6 unchanged. The serial stream that follows is then compared bit by bit with a model of the tap, and so are the done-flag timing of the count.

// File: rtl/slu_pkg.sv
package slu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    MD_STORE = 2'b00,
    MD_LOAD  = 2'b01,
    MD_SHIFT = 2'b10,
    MD_IDLE  = 2'b11
  } mode_e;
endpackage

// File: rtl/slu_lanesel.sv
module slu_lanesel #(
  parameter int LANES = 4,
  parameter int OFS_W = 2
) (
  input  logic [1:0]       size,
  input  logic [OFS_W-1:0] ofs,
  output logic [LANES-1:0] sel,
  output logic             misalign
);
  import slu_pkg::*;

  logic is_half;
  logic is_word;

  assign is_half = (size == SZ_HALF);
  assign is_word = size[1];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [OFS_W-1:0] KO = OFS_W'(k);
    logic hit_ofs;
    logic hit_word;
    logic hit_half;
    assign hit_ofs = (ofs == KO);
    if (k == 0) begin : g_first
      assign hit_word = 1'b0;
    end else begin : g_rest
      assign hit_word = is_word;
    end
    if (k % 2 == 1) begin : g_odd
      assign hit_half = is_half & (ofs[OFS_W-1] == KO[OFS_W-1]);
    end else begin : g_even
      assign hit_half = 1'b0;
    end
    assign sel[k] = hit_ofs | hit_word | hit_half;
  end

  assign misalign = (is_half & ofs[0]) | (is_word & (|ofs));
endmodule

// File: rtl/slu_chain.sv
module slu_chain #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  parameter int SHC_W  = 6,
  localparam int W     = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [W-1:0]     cap_data,
  input  logic             shl,
  input  logic [SHC_W-1:0] shl_amt,
  input  logic             st_step,
  input  logic             ld_step,
  input  logic             sh_step,
  input  logic             ser_in,
  output logic [W-1:0]     q
);
  logic [W-1:0] nxt;
  logic         full_upd;
  logic         cnt_upd;

  assign full_upd = cap | st_step | ld_step;
  assign cnt_upd  = shl | sh_step;

  always_comb begin
    nxt = q;
    if (cap) begin
      nxt = cap_data;
    end else if (shl) begin
      nxt[SHC_W-1:0] = shl_amt;
    end else if (st_step) begin
      nxt = {ser_in, q[W-1:1]};
    end else if (ld_step) begin
      nxt = {1'b0, q[W-1:1]};
    end else if (sh_step) begin
      nxt[SHC_W-1:0] = q[SHC_W-1:0] - 1'b1;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_stage
    logic lane_en;
    if (k * LANE_W < SHC_W) begin : g_cnt
      assign lane_en = full_upd | cnt_upd;
    end else begin : g_data
      assign lane_en = full_upd;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[k*LANE_W +: LANE_W] <= '0;
      end else if (lane_en) begin
        q[k*LANE_W +: LANE_W] <= nxt[k*LANE_W +: LANE_W];
      end
    end
  end

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (q == $past(cap_data)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap | shl | st_step | ld_step | sh_step) |=> $stable(q));
endmodule

// File: rtl/slu_tap.sv
module slu_tap #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  parameter int OFS_W  = 2,
  localparam int CNT_W = $clog2(LANE_W * LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] taps,
  input  logic [OFS_W-1:0] ofs,
  input  logic [1:0]       size,
  input  logic             signed_ld,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             step,
  output logic             rd_bit
);
  import slu_pkg::*;

  localparam logic [CNT_W:0] BYTE_LIM = (CNT_W + 1)'(LANE_W);
  localparam logic [CNT_W:0] HALF_LIM = (CNT_W + 1)'(2 * LANE_W);

  logic tap;
  logic valid;
  logic sign_q;
  logic sign_d;
  logic sign_en;

  assign tap = taps[ofs];

  always_comb begin
    if (size[1]) begin
      valid = 1'b1;
    end else if (size == SZ_HALF) begin
      valid = ({1'b0, bit_cnt} < HALF_LIM);
    end else begin
      valid = ({1'b0, bit_cnt} < BYTE_LIM);
    end
  end

  assign sign_en = step & valid;
  assign sign_d  = tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_q <= 1'b0;
    end else if (sign_en) begin
      sign_q <= sign_d;
    end
  end

  assign rd_bit = valid ? tap : (signed_ld & sign_q);

  a_r7_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !signed_ld) |-> !rd_bit);
endmodule

// File: rtl/slu_shctl.sv
module slu_shctl (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  output logic done_r
);
  logic done_d;

  assign done_d = done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_r <= 1'b0;
    end else begin
      done_r <= done_d;
    end
  end
endmodule

// File: rtl/serial_lane_unit.sv
module serial_lane_unit #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  parameter int SHC_W  = 6,
  localparam int W     = LANE_W * LANES,
  localparam int OFS_W = $clog2(LANES),
  localparam int CNT_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [1:0]       size,
  input  logic [OFS_W-1:0] addr_lsb,
  input  logic             en,
  input  logic             rs2_bit,
  input  logic             ld_capture,
  input  logic [W-1:0]     bus_rdat,
  input  logic             signed_ld,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             sh_load,
  input  logic [SHC_W-1:0] sh_amt,
  output logic [W-1:0]     wdat,
  output logic [LANES-1:0] byte_sel,
  output logic             misalign,
  output logic             rd_bit,
  output logic             sh_done,
  output logic             sh_done_r
);
  import slu_pkg::*;

  logic             m_store;
  logic             m_load;
  logic             m_shift;
  logic             cap;
  logic             shl;
  logic             st_step;
  logic             ld_step;
  logic             sh_step;
  logic [W-1:0]     q;
  logic [LANES-1:0] taps;

  assign m_store = (mode == MD_STORE);
  assign m_load  = (mode == MD_LOAD);
  assign m_shift = (mode == MD_SHIFT);

  assign cap     = m_load & ld_capture;
  assign shl     = m_shift & sh_load;
  assign st_step = m_store & en;
  assign ld_step = m_load & en & ~ld_capture;
  assign sh_done = m_shift & (q[SHC_W-1:0] == '0);
  assign sh_step = m_shift & en & ~sh_load & ~sh_done;

  slu_lanesel #(.LANES(LANES), .OFS_W(OFS_W)) u_sel (
    .size     (size),
    .ofs      (addr_lsb),
    .sel      (byte_sel),
    .misalign (misalign)
  );

  slu_chain #(.LANE_W(LANE_W), .LANES(LANES), .SHC_W(SHC_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (cap),
    .cap_data (bus_rdat),
    .shl      (shl),
    .shl_amt  (sh_amt),
    .st_step  (st_step),
    .ld_step  (ld_step),
    .sh_step  (sh_step),
    .ser_in   (rs2_bit),
    .q        (q)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_tap
    assign taps[k] = q[k*LANE_W];
  end

  slu_tap #(.LANE_W(LANE_W), .LANES(LANES), .OFS_W(OFS_W)) u_tap (
    .clk       (clk),
    .rst_n     (rst_n),
    .taps      (taps),
    .ofs       (addr_lsb),
    .size      (size),
    .signed_ld (signed_ld),
    .bit_cnt   (bit_cnt),
    .step      (ld_step),
    .rd_bit    (rd_bit)
  );

  slu_shctl u_done (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (sh_done),
    .done_r (sh_done_r)
  );

  assign wdat = q;

  a_r2_byte_single: assert property (@(posedge clk) disable iff (!rst_n)
    (size == SZ_BYTE) |-> ($countones(byte_sel) == 1));

  a_r3_word_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (size == SZ_WORD && addr_lsb != '0) |-> misalign);

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_done && en && !sh_load) |=> $stable(wdat));

  a_r9_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    sh_done |=> sh_done_r);

  a_r9_done_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_done |=> !sh_done_r);
endmodule

// File: tb/sim_serial_lane_unit.sv
`timescale 1ns/1ps
module sim_serial_lane_unit;
  logic        clk;
  logic        rst_n;
  logic [1:0]  mode;
  logic [1:0]  size;
  logic [1:0]  addr_lsb;
  logic        en;
  logic        rs2_bit;
  logic        ld_capture;
  logic [31:0] bus_rdat;
  logic        signed_ld;
  logic [4:0]  bit_cnt;
  logic        sh_load;
  logic [5:0]  sh_amt;
  logic [31:0] wdat;
  logic [3:0]  byte_sel;
  logic        misalign;
  logic        rd_bit;
  logic        sh_done;
  logic        sh_done_r;

  int total;
  int bad;
  bit finished;

  serial_lane_unit u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .size(size), .addr_lsb(addr_lsb),
    .en(en), .rs2_bit(rs2_bit), .ld_capture(ld_capture), .bus_rdat(bus_rdat),
    .signed_ld(signed_ld), .bit_cnt(bit_cnt), .sh_load(sh_load), .sh_amt(sh_amt),
    .wdat(wdat), .byte_sel(byte_sel), .misalign(misalign), .rd_bit(rd_bit),
    .sh_done(sh_done), .sh_done_r(sh_done_r)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] exp_sel(input logic [1:0] sz, input logic [1:0] o);
    logic h;
    logic w;
    h = (sz == 2'b01);
    w = (sz == 2'b10);
    exp_sel[0] = (o == 2'd0);
    exp_sel[1] = (o == 2'd1) | w | (h & ~o[1]);
    exp_sel[2] = (o == 2'd2) | w;
    exp_sel[3] = (o == 2'd3) | w | (h & o[1]);
  endfunction

  function automatic logic exp_mis(input logic [1:0] sz, input logic [1:0] o);
    return ((sz == 2'b01) && o[0]) || ((sz == 2'b10) && (o != 2'd0));
  endfunction

  function automatic logic exp_bit(input logic [31:0] w, input logic [1:0] sz,
                                   input logic [1:0] o, input logic sg, input int j);
    int lim;
    int base;
    lim  = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    base = 8 * o;
    if (j < lim) return (base + j < 32) ? w[base + j] : 1'b0;
    return sg ? w[base + lim - 1] : 1'b0;
  endfunction

  task automatic run_load(input logic [31:0] w, input logic [1:0] sz,
                          input logic [1:0] o, input logic sg, input logic en_cap);
    mode = 2'b01; size = sz; addr_lsb = o; signed_ld = sg;
    bus_rdat = w; ld_capture = 1'b1; en = en_cap; bit_cnt = 5'd0;
    tick();
    ld_capture = 1'b0;
    bus_rdat = ~w;
    check("R5 capture", wdat, w);
    for (int j = 0; j < 32; j++) begin
      bit_cnt = 5'(j);
      en = 1'b1;
      #1;
      if (j < ((sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32))
        check("R6 serial tap", {31'd0, rd_bit}, {31'd0, exp_bit(w, sz, o, sg, j)});
      else
        check("R7 fill", {31'd0, rd_bit}, {31'd0, exp_bit(w, sz, o, sg, j)});
      tick();
    end
    en = 1'b0;
  endtask

  task automatic run_shift(input logic [5:0] a, input logic en_ld);
    logic [25:0] up;
    int rem;
    logic pd;
    mode = 2'b10;
    up = wdat[31:6];
    sh_load = 1'b1; sh_amt = a; en = en_ld;
    tick();
    sh_load = 1'b0; sh_amt = ~a;
    check("R8 count load", {26'd0, wdat[5:0]}, {26'd0, a});
    check("R8 upper untouched", {6'd0, wdat[31:6]}, {6'd0, up});
    rem = a;
    check("R8 done after load", {31'd0, sh_done}, {31'd0, rem == 0});
    for (int i = 0; i < 80; i++) begin
      en = ($urandom % 4) != 0;
      pd = (rem == 0);
      tick();
      if (en && rem > 0) rem--;
      check("R8 done", {31'd0, sh_done}, {31'd0, rem == 0});
      check("R9 done reg", {31'd0, sh_done_r}, {31'd0, pd});
      if (rem == 0 && i > 2 && ($urandom % 3) == 0) break;
    end
    en = 1'b0;
  endtask

  initial begin
    logic [31:0] m;
    total = 0; bad = 0; finished = 0;
    void'($urandom(32'h1357_2468));
    rst_n = 1'b0; mode = 2'b00; size = 2'b00; addr_lsb = 2'd0; en = 1'b0;
    rs2_bit = 1'b0; ld_capture = 1'b0; bus_rdat = '0; signed_ld = 1'b0;
    bit_cnt = '0; sh_load = 1'b0; sh_amt = '0;
    #23;
    check("R1 reset wdat", wdat, 32'd0);
    check("R1 reset done_r", {31'd0, sh_done_r}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R1 idle wdat", wdat, 32'd0);
    check("R1 idle done_r", {31'd0, sh_done_r}, 32'd0);

    for (int s = 0; s < 3; s++) begin
      for (int o = 0; o < 4; o++) begin
        size = 2'(s); addr_lsb = 2'(o);
        #1;
        check("R2 byte select", {28'd0, byte_sel}, {28'd0, exp_sel(2'(s), 2'(o))});
        check("R3 misalign", {31'd0, misalign}, {31'd0, exp_mis(2'(s), 2'(o))});
      end
    end

    mode = 2'b00;
    m = wdat;
    for (int i = 0; i < 120; i++) begin
      en = (i < 32) ? 1'b1 : (($urandom % 3) != 0);
      rs2_bit = 1'($urandom);
      ld_capture = 1'($urandom);
      tick();
      if (en) m = {rs2_bit, m[31:1]};
      if (en) check("R4 store shift", wdat, m);
      else    check("R6 hold", wdat, m);
    end
    en = 1'b0; ld_capture = 1'b0;

    run_load(32'h8000_0080, 2'b00, 2'd0, 1'b1, 1'b0);
    run_load(32'h0000_8000, 2'b01, 2'd0, 1'b1, 1'b1);
    run_load(32'hFFFF_7FFF, 2'b01, 2'd2, 1'b1, 1'b0);
    run_load(32'h8000_0000, 2'b00, 2'd3, 1'b0, 1'b1);
    run_load(32'hDEAD_BEEF, 2'b10, 2'd0, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) begin
      logic [1:0] sz;
      logic [1:0] o;
      sz = 2'($urandom % 3);
      o = (sz == 2'b10) ? 2'd0 : (sz == 2'b01) ? {1'($urandom), 1'b0} : 2'($urandom);
      run_load($urandom, sz, o, 1'($urandom), 1'($urandom));
    end

    mode = 2'b01; en = 1'b0;
    m = wdat;
    tick();
    check("R6 hold no enable", wdat, m);

    run_shift(6'd0, 1'b1);
    run_shift(6'd1, 1'b0);
    run_shift(6'd63, 1'b1);
    for (int i = 0; i < 4; i++) run_shift(6'($urandom % 40), 1'($urandom));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule